// File: doc/BRIEF.md
# Single-Wire Latching Shift Receiver

This block is the receive end of a one-wire link to a character display. A single serial line does two jobs. Every low-to-high transition of the line clocks an 8-stage shift register. The bit shifted in is not the line itself but a persistence-filtered copy of it. That copy takes a new level only after the line has held that level for `SETTLE` consecutive clock cycles. A transmitter therefore sends a one by dipping the line low briefly before the rising edge. It sends a zero by holding the line low long enough for the filtered copy to follow, then raising it.

Each frame begins with a marker one. Once eight rising edges have occurred, the marker sits in the top shift stage. That stage drives the latch/enable signal. A rising enable copies all shift stages into the parallel output register. A falling enable is the moment the display takes the data, and the block marks it with a one-cycle strobe.

Two clear schemes are selected by `hw_clr_i`:
- **Automatic clear.** Once both the latched top bit and the top shift stage are high for `CLR_DLY` cycles, the shift stages are emptied.
- **Transmitter-driven clear.** Enable is additionally gated by a slow-filtered copy of the line. The transmitter drops enable by holding the line low, then flushes the stages with quick zero pulses.

The display link is write-only, so nothing is returned to the transmitter.

Top module: `swl_rx_top`

## Requirements
- R1: After reset the parallel outputs `nib_o`, `rs_o` and `bl_o` are 0, and `en_o` and `strobe_o` are 0.
- R2: The shift stages move one place toward the top stage on each low-to-high transition of `line_i`, and hold otherwise. The first bit of a frame reaches the top stage on the 8th rising edge, not before.
- R3: The bit shifted in is the filtered line level. The filtered level changes only after `line_i` has differed from it for `SETTLE` consecutive cycles. A low excursion shorter than that shifts in a 1; a low held for at least `SETTLE` cycles shifts in a 0.
- R4: Bits are shifted top-stage first in this order: marker 1, register select, backlight, D4, D5, D6, D7, unused. Outputs are `rs_o` = register select, `bl_o` = backlight, and `nib_o` = {D7, D6, D5, D4}.
- R5: A rising `en_o` copies the shift stages to the parallel outputs. At all other times the outputs hold, including while the next frame is shifted in.
- R6: With `hw_clr_i` = 1, `en_o` follows the top shift stage. Once the latched top bit and the top stage have both been high for `CLR_DLY` cycles, the stages are cleared and `en_o` falls, while the outputs keep their latched values.
- R7: With `hw_clr_i` = 0, `en_o` is the top stage ANDed with a copy of the line filtered over `EN_SETTLE` cycles. It stays high while the line stays high after a frame, and it is low on an idle high line with empty stages.
- R8: With `hw_clr_i` = 0, after enable has fallen, eight short high pulses shift zeros into the stages. These pulses neither raise `en_o` nor change the outputs.
- R9: `strobe_o` is high for exactly one cycle, in the cycle after each falling edge of `en_o`, giving one strobe per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Single serial line, synchronous to clk |
| hw_clr_i | input | 1 | 1 = automatic clear, 0 = transmitter-driven clear |
| en_o | output | 1 | Latch / display enable level |
| nib_o | output | 4 | Latched data nibble {D7,D6,D5,D4} |
| rs_o | output | 1 | Latched register select |
| bl_o | output | 1 | Latched backlight control |
| strobe_o | output | 1 | One-cycle pulse after enable falls |

## Verification
The hardest state to reach from the ports is the transmitter-driven flush. Enable has already fallen, and the stages still hold the frame with the marker near the top. Quick pulses must then shift zeros without the slow filter re-raising enable. The bench gets there by running a complete frame, holding the line high to show enable stays up, and holding it low past both filter lengths. It then issues eight one-cycle high pulses, and finally confirms that no extra strobe occurred, the outputs are unchanged, and a following frame decodes correctly.

// File: rtl/swl_rx_pkg.sv
// Package: shared constants for the single-wire receiver.
// Assumes an 8-stage register with the marker in the top stage.
package swl_rx_pkg;
    localparam int SR_W     = 8;
    localparam int MARK_BIT = 7;
    localparam int RS_BIT   = 6;
    localparam int BL_BIT   = 5;
    localparam int D4_BIT   = 4;
    localparam int D5_BIT   = 3;
    localparam int D6_BIT   = 2;
    localparam int D7_BIT   = 1;

    // Gather the data nibble {D7,D6,D5,D4} from a register image.
    function automatic logic [3:0] pick_nib(input logic [SR_W-1:0] img);
        return {img[D7_BIT], img[D6_BIT], img[D5_BIT], img[D4_BIT]};
    endfunction
endpackage

// File: rtl/swl_lvl_filter.sv
// Module: level-persistence filter.
// The output takes the input level only after the input has differed
// from the output for SETTLE consecutive cycles. It resets to high (idle line).
// Assumes SETTLE >= 1 and an input synchronous to clk.
module swl_lvl_filter #(
    parameter int SETTLE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic lvl_o
);
    localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [CW-1:0] LIM = CW'(SETTLE - 1);

    logic [CW-1:0] run_cnt;

    // Count consecutive differing cycles, and adopt the input level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            lvl_o   <= 1'b1;
        end else if (lvl_i != lvl_o) begin
            if (run_cnt == LIM) begin
                run_cnt <= '0;
                lvl_o   <= lvl_i;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
        end
    end

    // R3: the filtered level moves only when the run reached its limit
    p_filt_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_o != $past(lvl_o)) |-> ($past(run_cnt) == LIM));
endmodule

// File: rtl/swl_shift_latch.sv
// Module: shift stages plus parallel latch register.
// Stages shift on shift_i, empty on clr_i (clear wins), and are copied
// to par_o on latch_i. Clearing never touches par_o.
module swl_shift_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         bit_i,
    input  logic         clr_i,
    input  logic         latch_i,
    output logic [W-1:0] stage_o,
    output logic [W-1:0] par_o
);
    // Shift stages: clear has priority over a shift in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       stage_o <= '0;
        else if (clr_i)   stage_o <= '0;
        else if (shift_i) stage_o <= {stage_o[W-2:0], bit_i};
    end

    // Parallel register: captures the stages on a latch pulse only.
    always_ff @(posedge clk) begin
        if (!rst_n)       par_o <= '0;
        else if (latch_i) par_o <= stage_o;
    end

    // R2: stages hold unless shifted or cleared
    p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(shift_i) && !$past(clr_i)) |-> (stage_o == $past(stage_o)));
    // R6: a clear request leaves every stage empty
    p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> (stage_o == '0));
    // R5: outputs change only on a latch pulse
    p_par_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(latch_i) |-> (par_o == $past(par_o)));
endmodule

// File: rtl/swl_clr_timer.sv
// Module: automatic-clear delay.
// When armed and both the latched top bit and the top stage are high for
// DLY consecutive cycles, it issues a one-cycle clear request. Assumes DLY >= 1.
module swl_clr_timer #(
    parameter int DLY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic qh_i,
    input  logic qph_i,
    output logic clr_o
);
    localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;
    localparam logic [CW-1:0] LIM = CW'(DLY - 1);

    logic          both;
    logic [CW-1:0] dly_cnt;

    // Both-high condition gated by the mode.
    always_comb both = arm_i && qh_i && qph_i;

    // Delay counter: runs while the condition holds and restarts at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)              dly_cnt <= '0;
        else if (!both)          dly_cnt <= '0;
        else if (dly_cnt == LIM) dly_cnt <= '0;
        else                     dly_cnt <= dly_cnt + 1'b1;
    end

    // Clear request in the last cycle of the delay.
    always_comb clr_o = both && (dly_cnt == LIM);
endmodule

// File: rtl/swl_rx_top.sv
// Module: single-wire latching shift receiver top.
// Rising line edges shift in the filtered line level. The top stage
// (optionally gated by a slow line filter) forms latch/enable. A rising
// enable latches the stages, and a falling enable gives a one-cycle strobe.
// Assumes line_i is already synchronous to clk.
module swl_rx_top
    import swl_rx_pkg::*;
#(
    parameter int SETTLE    = 8,
    parameter int EN_SETTLE = 8,
    parameter int CLR_DLY   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    input  logic       hw_clr_i,
    output logic       en_o,
    output logic [3:0] nib_o,
    output logic       rs_o,
    output logic       bl_o,
    output logic       strobe_o
);
    logic            line_q;
    logic            rise;
    logic            data_lvl;
    logic            slow_lvl;
    logic            clr_req;
    logic            en_q;
    logic            latch_rise;
    logic [SR_W-1:0] stage;
    logic [SR_W-1:0] par;

    // Previous line level, for edge detection (idle high).
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= line_i;
    end

    // Low-to-high transition of the serial line.
    always_comb rise = line_i && !line_q;

    swl_lvl_filter #(.SETTLE(SETTLE)) u_data_filt (
        .clk(clk), .rst_n(rst_n), .lvl_i(line_i), .lvl_o(data_lvl)
    );

    swl_lvl_filter #(.SETTLE(EN_SETTLE)) u_en_filt (
        .clk(clk), .rst_n(rst_n), .lvl_i(line_i), .lvl_o(slow_lvl)
    );

    swl_shift_latch #(.W(SR_W)) u_sr (
        .clk(clk), .rst_n(rst_n), .shift_i(rise), .bit_i(data_lvl),
        .clr_i(clr_req), .latch_i(latch_rise), .stage_o(stage), .par_o(par)
    );

    swl_clr_timer #(.DLY(CLR_DLY)) u_clr (
        .clk(clk), .rst_n(rst_n), .arm_i(hw_clr_i),
        .qh_i(par[MARK_BIT]), .qph_i(stage[MARK_BIT]), .clr_o(clr_req)
    );

    // Enable: top stage, gated by the slow line copy in transmitter-clear mode.
    always_comb en_o = stage[MARK_BIT] && (hw_clr_i || slow_lvl);

    // Previous enable level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_o;
    end

    // Latch on the rising enable.
    always_comb latch_rise = en_o && !en_q;

    // Strobe registered from the falling enable.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_o <= 1'b0;
        else        strobe_o <= en_q && !en_o;
    end

    // Field mapping of the latched image onto the outputs.
    always_comb begin
        nib_o = pick_nib(par);
        rs_o  = par[RS_BIT];
        bl_o  = par[BL_BIT];
    end

    // R9: strobe never lasts two cycles
    p_strobe_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);
endmodule

// File: tb/swl_rx_top_test.sv
module swl_rx_top_test;
    localparam int SETTLE    = 8;
    localparam int EN_SETTLE = 8;
    localparam int CLR_DLY   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_i = 1'b1;
    logic       hw_clr_i = 1'b1;
    logic       en_o;
    logic [3:0] nib_o;
    logic       rs_o;
    logic       bl_o;
    logic       strobe_o;

    int checks = 0;
    int failures = 0;
    int stb_cnt = 0;
    logic [5:0] cap = '0;

    always #5 clk = ~clk;

    swl_rx_top #(.SETTLE(SETTLE), .EN_SETTLE(EN_SETTLE), .CLR_DLY(CLR_DLY)) uut (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .hw_clr_i(hw_clr_i),
        .en_o(en_o), .nib_o(nib_o), .rs_o(rs_o), .bl_o(bl_o), .strobe_o(strobe_o)
    );

    // Strobe monitor: counts strobe cycles and captures the fields at each strobe.
    always @(posedge clk) begin
        if (rst_n && strobe_o) begin
            stb_cnt <= stb_cnt + 1;
            cap     <= {rs_o, bl_o, nib_o};
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One bit: a short low dip gives 1, a long low gives 0 (R3).
    task automatic send_bit(input logic b);
        if (b) begin
            line_i = 1'b0; wait_n(2);
            line_i = 1'b1; wait_n(3);
        end else begin
            line_i = 1'b0; wait_n(SETTLE + 2);
            line_i = 1'b1; wait_n(SETTLE + 2);
        end
    endtask

    // R4: frame byte, top stage first.
    function automatic logic [7:0] frame_byte(input logic rs, input logic bl, input logic [3:0] n);
        return {1'b1, rs, bl, n[0], n[1], n[2], n[3], 1'b1};
    endfunction

    task automatic do_reset(input logic hw);
        hw_clr_i = hw;
        line_i = 1'b1;
        rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
    endtask

    task automatic t_reset();
        do_reset(1'b1);
        chk("R1 nib", nib_o, 0);
        chk("R1 rs/bl", {rs_o, bl_o}, 0);
        chk("R1 en/strobe", {en_o, strobe_o}, 0);
    endtask

    task automatic hw_frame(input logic rs, input logic bl, input logic [3:0] n, input logic first);
        logic [7:0] fb;
        int s0;
        logic [5:0] old;
        fb = frame_byte(rs, bl, n);
        s0 = stb_cnt;
        old = {rs_o, bl_o, nib_o};
        for (int i = 7; i >= 1; i--) send_bit(fb[i]);
        if (first) chk("R2 en low after 7 edges", en_o, 0);
        chk("R5 outputs held during shift", {rs_o, bl_o, nib_o}, old);
        send_bit(fb[0]);
        chk("R2 en high after 8th edge", en_o, 1);
        wait_n(CLR_DLY + 10);
        chk("R6 en fell after auto clear", en_o, 0);
        chk("R9 one strobe per frame", stb_cnt - s0, 1);
        chk("R4 strobe data", cap, {rs, bl, n});
        chk("R6 outputs kept after clear", {rs_o, bl_o, nib_o}, {rs, bl, n});
    endtask

    task automatic t_hw();
        do_reset(1'b1);
        hw_frame(1'b1, 1'b0, 4'hA, 1'b1);
        hw_frame(1'b0, 1'b1, 4'h5, 1'b0);
        hw_frame(1'b1, 1'b1, 4'h0, 1'b0);
        hw_frame(1'b0, 1'b0, 4'hF, 1'b0);
    endtask

    task automatic sw_frame(input logic rs, input logic bl, input logic [3:0] n);
        logic [7:0] fb;
        int s0;
        fb = frame_byte(rs, bl, n);
        s0 = stb_cnt;
        for (int i = 7; i >= 0; i--) send_bit(fb[i]);
        wait_n(EN_SETTLE + 4);
        chk("R7 en high while line high", en_o, 1);
        wait_n(30);
        chk("R7 en still high, no strobe", {en_o, 1'(stb_cnt != s0)}, 2'b10);
        line_i = 1'b0;
        wait_n(EN_SETTLE + 4);
        chk("R7 en low after line low", en_o, 0);
        chk("R9 one strobe on sw fall", stb_cnt - s0, 1);
        chk("R4 sw strobe data", cap, {rs, bl, n});
        for (int k = 0; k < 8; k++) begin
            line_i = 1'b1; wait_n(1);
            line_i = 1'b0; wait_n(2);
        end
        line_i = 1'b1;
        wait_n(SETTLE + 4);
        chk("R8 flush no extra strobe", stb_cnt - s0, 1);
        chk("R8 flush keeps outputs", {rs_o, bl_o, nib_o}, {rs, bl, n});
        chk("R8 flush en low", en_o, 0);
    endtask

    task automatic t_sw();
        do_reset(1'b0);
        wait_n(20);
        chk("R7 idle high, empty stages, en low", en_o, 0);
        sw_frame(1'b0, 1'b1, 4'hC);
        sw_frame(1'b1, 1'b0, 4'h3);
    endtask

    initial begin
        t_reset();
        t_hw();
        t_sw();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule